// File: doc/BRIEF.md
# Timer Control Register Access Checker

This block decides, in one combinational pass, what happens when software touches the physical-timer control register. It takes the current privilege level (0 to 3), the width mode of levels 1, 2 and 3, the level-2-enabled and host-mode flags, the trap-general bit, the timer access enables held at levels 1 and 2, the security state and two feature-presence flags. From these it reports one of five outcomes, a 6-bit syndrome for traps, and which of five register banks the access targets.

The checks run in a fixed first-match order. A lower-level user enable is tested first, then the level-2 counter and host enables, and the 32-bit hypervisor counter enable last. The first failing check picks both the outcome and the syndrome. A permitted access then picks its bank from the host, security and level-3 state. Reads and writes go through the same decision. The datapath half turns a permitted write into a single per-bank write strobe. It returns the selected bank's value for a permitted read and zero for anything else.

Top module: `timer_access_gate`

## Requirements
- R1: `outcome` is one-hot with bit 0 allow, bit 1 trap to level 1, bit 2 trap to level 2, bit 3 hypervisor trap and bit 4 undefined. It is all zero when `accValid` is 0.
- R2: `syndrome` is 0x03 for traps to level 1 or 2. It is 0x03 or 0x00 for a hypervisor trap, as the rules below state. It is 0x00 for allow, undefined or no access.
- R3: At level 0, with level 1 in 64-bit mode, `hostEl0` low and `usrTimEn64` low, the access traps with syndrome 0x03. It goes to level 2 when level 2 is enabled, 64-bit and `trapGeneral` is set, and to level 1 otherwise. With `hostEl0` high this check is skipped.
- R4: At level 0, with level 1 in 32-bit mode and `usrTimEn32` low, the result depends on level 2 and `trapGeneral`. An enabled 64-bit level 2 with the bit set gives a trap to level 2 with 0x03. An enabled 32-bit level 2 with the bit set gives a hypervisor trap with 0x00. Any other case is undefined.
- R5: After R3 and R4, level 0 traps to level 2 with 0x03 in three cases. The first is an enabled 64-bit, non-host level 2 with `hypCntEn64` low. The second is `hostEl2` high with `trapGeneral` low and `hostL1TimEn` low. The third is `hostEl0` high with `hostL0TimEn` low.
- R6: Last in priority, an enabled 32-bit level 2 with `hypCntEn32` low gives a hypervisor trap with 0x03. Any earlier check that fails takes precedence.
- R7: Bank codes are 0 local, 1 secure, 2 non-secure, 3 hypervisor non-secure and 4 hypervisor secure. `bankSel` is 0 unless the outcome is allow. A permitted level-0 access with `hostEl0` high selects 4 when secure with `hasSecEl2`, and 3 when non-secure. Otherwise it selects 0.
- R8: At level 1 the three level-2 checks of R5 (first two cases) and R6 apply, with `trapGeneral` ignored in the host check. The user enables have no effect at level 1.
- R9: A permitted access at level 1, and every access at level 2, selects bank 2 when level 3 is present and 32-bit. Otherwise it selects bank 0. Level 2 never traps.
- R10: At level 3 the access is always allowed. `nsSelect` 0 selects bank 1 and 1 selects bank 2.
- R11: `bankWrEn` has exactly the selected bank's bit set only for a permitted write. Otherwise it is zero.
- R12: For a permitted read, `rdData` is the selected bank's slice of `bankRdData` and `rdValid` is 1. A denied read, any write and no access give `rdData` 0 and `rdValid` 0. Read and write get the same outcome, syndrome and bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| accValid | input | 1 | An access is being decided |
| accWrite | input | 1 | 1 write, 0 read |
| curLevel | input | 2 | Current privilege level |
| el1Is32 | input | 1 | Level 1 runs 32-bit |
| el2Is32 | input | 1 | Level 2 runs 32-bit |
| el3Is32 | input | 1 | Level 3 runs 32-bit |
| el2Enabled | input | 1 | Level 2 is enabled |
| el3Present | input | 1 | Level 3 exists |
| hostEl0 | input | 1 | Level 0 runs under a host-mode level 2 |
| hostEl2 | input | 1 | Level 2 is in host mode |
| trapGeneral | input | 1 | Route level-0 exceptions to level 2 |
| usrTimEn64 | input | 1 | User timer enable, 64-bit level 1 control |
| usrTimEn32 | input | 1 | User timer enable, 32-bit level 1 control |
| hypCntEn64 | input | 1 | Level-1 counter enable, 64-bit level 2 control |
| hypCntEn32 | input | 1 | Level-1 counter enable, 32-bit level 2 control |
| hostL1TimEn | input | 1 | Host-mode level-1 timer enable |
| hostL0TimEn | input | 1 | Host-mode level-0 timer enable |
| secureState | input | 1 | Current state is secure |
| hasSecEl2 | input | 1 | Secure level 2 feature present |
| nsSelect | input | 1 | Level-3 non-secure select |
| wrData | input | DATA_W | Write data, passed to storage alongside strobes |
| bankRdData | input | NUM_BANKS*DATA_W | Current value of every bank, bank 0 lowest |
| outcome | output | 5 | One-hot decision |
| syndrome | output | 6 | Trap syndrome |
| bankSel | output | 3 | Selected bank code |
| bankWrEn | output | NUM_BANKS | Per-bank write commit |
| bankWrData | output | DATA_W | Data to commit |
| rdData | output | DATA_W | Read return |
| rdValid | output | 1 | Read return is valid |

## Verification
The decision is tried with one vector per rule. Each vector fails exactly one enable against an otherwise permitting background, which shows that each check hits on its own input. Paired vectors flip a single routing input, such as `trapGeneral`, `hostEl0`, `hostEl2` or `el2Is32`, to separate the trap targets. They also show that a skipped check lets a later one decide. Vectors that fail an early and a late check together prove the priority order. Every vector is run as both a read and a write, which separates the write strobe from the read return and shows the decision is the same for both.

// File: rtl/tacc_pkg.sv
package tacc_pkg;

  localparam int OUTCOME_W = 5;
  localparam int SYND_W    = 6;
  localparam int NUM_BANKS = 5;
  localparam int BANK_W    = $clog2(NUM_BANKS);

  // bit positions in the one-hot outcome
  localparam int OC_ALLOW = 0;
  localparam int OC_TRAP1 = 1;
  localparam int OC_TRAP2 = 2;
  localparam int OC_HYP   = 3;
  localparam int OC_UNDEF = 4;

  localparam logic [SYND_W-1:0] SYN_TIMER = 6'h03;
  localparam logic [SYND_W-1:0] SYN_ZERO  = 6'h00;

  typedef enum logic [2:0] {
    V_ALLOW = 3'd0,
    V_TRAP1 = 3'd1,
    V_TRAP2 = 3'd2,
    V_HYP   = 3'd3,
    V_UNDEF = 3'd4
  } verdict_e;

  typedef enum logic [BANK_W-1:0] {
    BANK_LOCAL   = 3'd0,
    BANK_SEC     = 3'd1,
    BANK_NSEC    = 3'd2,
    BANK_HYP_NS  = 3'd3,
    BANK_HYP_SEC = 3'd4
  } bank_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [OUTCOME_W-1:0] outcome;
    logic [SYND_W-1:0]    syndrome;
    bank_e                bank;
  } accStrobes_t;

endpackage

// File: rtl/tacc_decide.sv
module tacc_decide
  import tacc_pkg::*;
(
  input  logic        accValid,
  input  logic [1:0]  curLevel,
  input  logic        el1Is32,
  input  logic        el2Is32,
  input  logic        el3Is32,
  input  logic        el2Enabled,
  input  logic        el3Present,
  input  logic        hostEl0,
  input  logic        hostEl2,
  input  logic        trapGeneral,
  input  logic        usrTimEn64,
  input  logic        usrTimEn32,
  input  logic        hypCntEn64,
  input  logic        hypCntEn32,
  input  logic        hostL1TimEn,
  input  logic        hostL0TimEn,
  input  logic        secureState,
  input  logic        hasSecEl2,
  input  logic        nsSelect,
  output accStrobes_t strobes
);

  // routing helpers
  logic routeToL2;
  logic hyp32Routed;
  logic legacyNsBank;

  // individual check failures
  logic usr64Miss;
  logic usr32Miss;
  logic cnt64Miss;
  logic hostTimMissL0;
  logic hostTimMissL1;
  logic hostUsrMiss;
  logic cnt32Miss;

  verdict_e          verdict;
  logic [SYND_W-1:0] synd;
  bank_e             bank;
  logic              isTrap;

  assign routeToL2     = el2Enabled && !el2Is32 && trapGeneral;
  assign hyp32Routed   = el2Enabled &&  el2Is32 && trapGeneral;
  assign legacyNsBank  = el3Present && el3Is32;

  assign usr64Miss     = !el1Is32 && !hostEl0 && !usrTimEn64;
  assign usr32Miss     =  el1Is32 && !usrTimEn32;
  assign cnt64Miss     = el2Enabled && !el2Is32 && !hostEl2 && !hypCntEn64;
  assign hostTimMissL0 = hostEl2 && !trapGeneral && !hostL1TimEn;
  assign hostTimMissL1 = hostEl2 && !hostL1TimEn;
  assign hostUsrMiss   = hostEl0 && !hostL0TimEn;
  assign cnt32Miss     = el2Enabled && el2Is32 && !hypCntEn32;

  // first-match priority chain per level
  always_comb begin
    verdict = V_ALLOW;
    synd    = SYN_ZERO;
    bank    = BANK_LOCAL;
    unique case (curLevel)
      2'd0: begin
        if (usr64Miss) begin
          verdict = routeToL2 ? V_TRAP2 : V_TRAP1;
          synd    = SYN_TIMER;
        end else if (usr32Miss) begin
          if (routeToL2) begin
            verdict = V_TRAP2;
            synd    = SYN_TIMER;
          end else if (hyp32Routed) begin
            verdict = V_HYP;
            synd    = SYN_ZERO;
          end else begin
            verdict = V_UNDEF;
          end
        end else if (cnt64Miss || hostTimMissL0 || hostUsrMiss) begin
          verdict = V_TRAP2;
          synd    = SYN_TIMER;
        end else if (cnt32Miss) begin
          verdict = V_HYP;
          synd    = SYN_TIMER;
        end else if (hostEl0 && secureState && hasSecEl2) begin
          bank = BANK_HYP_SEC;
        end else if (hostEl0 && !secureState) begin
          bank = BANK_HYP_NS;
        end else begin
          bank = BANK_LOCAL;
        end
      end
      2'd1: begin
        if (cnt64Miss || hostTimMissL1) begin
          verdict = V_TRAP2;
          synd    = SYN_TIMER;
        end else if (cnt32Miss) begin
          verdict = V_HYP;
          synd    = SYN_TIMER;
        end else begin
          bank = legacyNsBank ? BANK_NSEC : BANK_LOCAL;
        end
      end
      2'd2: begin
        bank = legacyNsBank ? BANK_NSEC : BANK_LOCAL;
      end
      default: begin
        bank = nsSelect ? BANK_NSEC : BANK_SEC;
      end
    endcase
  end

  assign isTrap = (verdict == V_TRAP1) || (verdict == V_TRAP2) || (verdict == V_HYP);

  always_comb begin
    strobes.outcome  = accValid ? (OUTCOME_W'(1) << verdict) : '0;
    strobes.syndrome = (accValid && isTrap) ? synd : SYN_ZERO;
    strobes.bank     = (accValid && verdict == V_ALLOW) ? bank : BANK_LOCAL;
  end

  // R1
  always_comb begin
    outcome_onehot_chk: assert (accValid ? $onehot(strobes.outcome)
                                         : (strobes.outcome == '0));
  end

  // R2
  always_comb begin
    if (strobes.outcome[OC_TRAP1] || strobes.outcome[OC_TRAP2])
      trap_synd_chk: assert (strobes.syndrome == SYN_TIMER);
  end

  // R2
  always_comb begin
    if (!(strobes.outcome[OC_TRAP1] || strobes.outcome[OC_TRAP2] ||
          strobes.outcome[OC_HYP]))
      synd_clear_chk: assert (strobes.syndrome == SYN_ZERO);
  end

  // R10
  always_comb begin
    if (accValid && curLevel >= 2'd2)
      upper_open_chk: assert (strobes.outcome[OC_ALLOW]);
  end

  // R7
  always_comb begin
    if (!strobes.outcome[OC_ALLOW])
      bank_idle_chk: assert (strobes.bank == BANK_LOCAL);
  end

endmodule

// File: rtl/tacc_datapath.sv
module tacc_datapath
  import tacc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB     = NUM_BANKS
) (
  input  accStrobes_t         strobes,
  input  logic                accWrite,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NB*DATA_W-1:0] bankRdData,
  output logic [NB-1:0]       bankWrEn,
  output logic [DATA_W-1:0]   bankWrData,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid
);

  logic          granted;
  logic [NB-1:0] rdHit;

  assign granted    = strobes.outcome[OC_ALLOW];
  assign bankWrData = wrData;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic sel;
    assign sel         = (strobes.bank == BANK_W'(b));
    assign bankWrEn[b] = granted &&  accWrite && sel;
    assign rdHit[b]    = granted && !accWrite && sel;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NB; i++) begin
      if (rdHit[i]) rdData = rdData | bankRdData[i*DATA_W +: DATA_W];
    end
  end

  assign rdValid = |rdHit;

  // R11
  always_comb begin
    wr_onehot_chk: assert ($onehot0(bankWrEn));
  end

  // R11
  always_comb begin
    if (|bankWrEn)
      wr_grant_chk: assert (strobes.outcome[OC_ALLOW] && accWrite);
  end

  // R12
  always_comb begin
    if (!rdValid)
      rd_quiet_chk: assert (rdData == '0);
  end

  // R12
  always_comb begin
    if (rdValid)
      rd_grant_chk: assert (strobes.outcome[OC_ALLOW] && !accWrite);
  end

endmodule

// File: rtl/timer_access_gate.sv
module timer_access_gate
  import tacc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          accValid,
  input  logic                          accWrite,
  input  logic [1:0]                    curLevel,
  input  logic                          el1Is32,
  input  logic                          el2Is32,
  input  logic                          el3Is32,
  input  logic                          el2Enabled,
  input  logic                          el3Present,
  input  logic                          hostEl0,
  input  logic                          hostEl2,
  input  logic                          trapGeneral,
  input  logic                          usrTimEn64,
  input  logic                          usrTimEn32,
  input  logic                          hypCntEn64,
  input  logic                          hypCntEn32,
  input  logic                          hostL1TimEn,
  input  logic                          hostL0TimEn,
  input  logic                          secureState,
  input  logic                          hasSecEl2,
  input  logic                          nsSelect,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_BANKS*DATA_W-1:0]   bankRdData,
  output logic [OUTCOME_W-1:0]          outcome,
  output logic [SYND_W-1:0]             syndrome,
  output logic [BANK_W-1:0]             bankSel,
  output logic [NUM_BANKS-1:0]          bankWrEn,
  output logic [DATA_W-1:0]             bankWrData,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdValid
);

  accStrobes_t strobes;

  tacc_decide u_decide (
    .accValid    (accValid),
    .curLevel    (curLevel),
    .el1Is32     (el1Is32),
    .el2Is32     (el2Is32),
    .el3Is32     (el3Is32),
    .el2Enabled  (el2Enabled),
    .el3Present  (el3Present),
    .hostEl0     (hostEl0),
    .hostEl2     (hostEl2),
    .trapGeneral (trapGeneral),
    .usrTimEn64  (usrTimEn64),
    .usrTimEn32  (usrTimEn32),
    .hypCntEn64  (hypCntEn64),
    .hypCntEn32  (hypCntEn32),
    .hostL1TimEn (hostL1TimEn),
    .hostL0TimEn (hostL0TimEn),
    .secureState (secureState),
    .hasSecEl2   (hasSecEl2),
    .nsSelect    (nsSelect),
    .strobes     (strobes)
  );

  tacc_datapath #(
    .DATA_W (DATA_W),
    .NB     (NUM_BANKS)
  ) u_datapath (
    .strobes    (strobes),
    .accWrite   (accWrite),
    .wrData     (wrData),
    .bankRdData (bankRdData),
    .bankWrEn   (bankWrEn),
    .bankWrData (bankWrData),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

  assign outcome  = strobes.outcome;
  assign syndrome = strobes.syndrome;
  assign bankSel  = strobes.bank;

endmodule

// File: tb/timer_access_gate_tb.sv
module timer_access_gate_tb;

  localparam int DW = 32;
  localparam int NB = 5;

  localparam logic [4:0] OK_ = 5'b00001;
  localparam logic [4:0] TL1 = 5'b00010;
  localparam logic [4:0] TL2 = 5'b00100;
  localparam logic [4:0] HYP = 5'b01000;
  localparam logic [4:0] UND = 5'b10000;

  typedef struct packed {
    logic [1:0] lvl;
    logic e1, e2, e3, e2en, h0, h2, tge, u64, u32, c64, c32, hl1, hl0, sec, sel2, e3p, ns;
    logic [4:0] eo;
    logic [5:0] es;
    logic [2:0] eb;
  } vec_t;

  localparam int NV = 24;
  // flag order: e1 e2 e3 e2en h0 h2 tge u64 u32 c64 c32 hl1 hl0 sec sel2 e3p ns
  localparam logic [32:0] VECS [NV] = '{
    {2'd0, 17'b0_0_0_1_0_0_1_0_1_1_1_1_1_0_0_0_0, TL2, 6'h03, 3'd0}, // R3 to level 2
    {2'd0, 17'b0_0_0_1_0_0_0_0_1_1_1_1_1_0_0_0_0, TL1, 6'h03, 3'd0}, // R3 to level 1
    {2'd0, 17'b0_0_0_1_1_0_0_0_1_1_1_1_1_0_0_0_0, OK_, 6'h00, 3'd3}, // R3 skipped in host
    {2'd0, 17'b1_0_0_1_0_0_1_1_0_1_1_1_1_0_0_0_0, TL2, 6'h03, 3'd0}, // R4
    {2'd0, 17'b1_1_0_1_0_0_1_1_0_1_1_1_1_0_0_0_0, HYP, 6'h00, 3'd0}, // R4
    {2'd0, 17'b1_1_0_1_0_0_0_1_0_1_1_1_1_0_0_0_0, UND, 6'h00, 3'd0}, // R4
    {2'd0, 17'b1_0_0_0_0_0_1_1_0_1_1_1_1_0_0_0_0, UND, 6'h00, 3'd0}, // R4
    {2'd0, 17'b0_0_0_1_0_0_0_1_1_0_1_1_1_0_0_0_0, TL2, 6'h03, 3'd0}, // R5 a
    {2'd0, 17'b0_0_0_1_0_1_0_1_1_0_1_1_1_0_0_0_0, OK_, 6'h00, 3'd0}, // R5 a skipped
    {2'd0, 17'b0_0_0_1_0_1_0_1_1_1_1_0_1_0_0_0_0, TL2, 6'h03, 3'd0}, // R5 b
    {2'd0, 17'b0_0_0_1_1_1_1_1_1_1_1_0_0_0_0_0_0, TL2, 6'h03, 3'd0}, // R5 c
    {2'd0, 17'b0_1_0_1_0_0_0_1_1_1_0_1_1_0_0_0_0, HYP, 6'h03, 3'd0}, // R6
    {2'd0, 17'b0_1_0_1_0_0_0_0_1_1_0_1_1_0_0_0_0, TL1, 6'h03, 3'd0}, // R6 loses priority
    {2'd0, 17'b0_0_0_1_1_0_0_1_1_1_1_1_1_1_1_0_0, OK_, 6'h00, 3'd4}, // R7
    {2'd0, 17'b0_0_0_1_1_0_0_1_1_1_1_1_1_1_0_0_0, OK_, 6'h00, 3'd0}, // R7
    {2'd1, 17'b1_0_0_1_0_0_0_0_0_0_1_1_1_0_0_0_0, TL2, 6'h03, 3'd0}, // R8
    {2'd1, 17'b0_0_0_1_0_1_1_1_1_1_1_0_1_0_0_0_0, TL2, 6'h03, 3'd0}, // R8
    {2'd1, 17'b0_1_0_1_0_0_0_1_1_1_0_1_1_0_0_0_0, HYP, 6'h03, 3'd0}, // R8
    {2'd1, 17'b0_0_1_1_0_0_0_1_1_1_1_1_1_0_0_1_0, OK_, 6'h00, 3'd2}, // R9
    {2'd1, 17'b0_0_0_1_0_0_0_1_1_1_1_1_1_0_0_1_0, OK_, 6'h00, 3'd0}, // R9
    {2'd2, 17'b0_0_1_1_0_0_0_0_0_0_0_0_0_0_0_1_0, OK_, 6'h00, 3'd2}, // R9
    {2'd3, 17'b0_0_0_1_0_0_0_0_0_0_0_0_0_0_0_0_0, OK_, 6'h00, 3'd1}, // R10
    {2'd3, 17'b0_0_0_1_0_0_0_0_0_0_0_0_0_0_0_0_1, OK_, 6'h00, 3'd2}, // R10
    {2'd0, 17'b0_0_0_1_1_0_0_1_1_1_1_1_1_0_1_0_0, OK_, 6'h00, 3'd3}  // R7
  };

  string vecReq [NV] = '{"R3", "R3", "R3", "R4", "R4", "R4", "R4", "R5", "R5", "R5",
                         "R5", "R6", "R6", "R7", "R7", "R8", "R8", "R8", "R9", "R9",
                         "R9", "R10", "R10", "R7"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic accValid, accWrite;
  logic [1:0] curLevel;
  logic el1Is32, el2Is32, el3Is32, el2Enabled, el3Present, hostEl0, hostEl2, trapGeneral;
  logic usrTimEn64, usrTimEn32, hypCntEn64, hypCntEn32, hostL1TimEn, hostL0TimEn;
  logic secureState, hasSecEl2, nsSelect;
  logic [DW-1:0] wrData;
  logic [NB*DW-1:0] bankRdData;
  logic [4:0] outcome;
  logic [5:0] syndrome;
  logic [2:0] bankSel;
  logic [NB-1:0] bankWrEn;
  logic [DW-1:0] bankWrData, rdData;
  logic rdValid;

  timer_access_gate #(.DATA_W(DW)) u_dut (
    .accValid(accValid), .accWrite(accWrite), .curLevel(curLevel),
    .el1Is32(el1Is32), .el2Is32(el2Is32), .el3Is32(el3Is32),
    .el2Enabled(el2Enabled), .el3Present(el3Present), .hostEl0(hostEl0),
    .hostEl2(hostEl2), .trapGeneral(trapGeneral), .usrTimEn64(usrTimEn64),
    .usrTimEn32(usrTimEn32), .hypCntEn64(hypCntEn64), .hypCntEn32(hypCntEn32),
    .hostL1TimEn(hostL1TimEn), .hostL0TimEn(hostL0TimEn), .secureState(secureState),
    .hasSecEl2(hasSecEl2), .nsSelect(nsSelect), .wrData(wrData),
    .bankRdData(bankRdData), .outcome(outcome), .syndrome(syndrome),
    .bankSel(bankSel), .bankWrEn(bankWrEn), .bankWrData(bankWrData),
    .rdData(rdData), .rdValid(rdValid)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  function automatic logic [DW-1:0] bankVal(int b);
    return 32'hC0DE_0000 | DW'(b * 17 + 1);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(vec_t v, logic wr);
    @(posedge clk);
    accValid = 1'b1; accWrite = wr; curLevel = v.lvl;
    el1Is32 = v.e1; el2Is32 = v.e2; el3Is32 = v.e3; el2Enabled = v.e2en;
    hostEl0 = v.h0; hostEl2 = v.h2; trapGeneral = v.tge;
    usrTimEn64 = v.u64; usrTimEn32 = v.u32; hypCntEn64 = v.c64; hypCntEn32 = v.c32;
    hostL1TimEn = v.hl1; hostL0TimEn = v.hl0; secureState = v.sec; hasSecEl2 = v.sel2;
    el3Present = v.e3p; nsSelect = v.ns;
    wrData = 32'h1234_5678 ^ {29'd0, v.eb};
  endtask

  task automatic checkIdle(string tag);
    chk("R1", {tag, " outcome"}, 32'(outcome), 32'd0);
    chk("R2", {tag, " syndrome"}, 32'(syndrome), 32'd0);
    chk("R11", {tag, " wrEn"}, 32'(bankWrEn), 32'd0);
    chk("R12", {tag, " rdData"}, rdData, 32'd0);
    chk("R12", {tag, " rdValid"}, 32'(rdValid), 32'd0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    accValid = 1'b0; accWrite = 1'b0; curLevel = 2'd0;
    el1Is32 = 1'b0; el2Is32 = 1'b0; el3Is32 = 1'b0; el2Enabled = 1'b0; el3Present = 1'b0;
    hostEl0 = 1'b0; hostEl2 = 1'b0; trapGeneral = 1'b0;
    usrTimEn64 = 1'b0; usrTimEn32 = 1'b0; hypCntEn64 = 1'b0; hypCntEn32 = 1'b0;
    hostL1TimEn = 1'b0; hostL0TimEn = 1'b0; secureState = 1'b0; hasSecEl2 = 1'b0;
    nsSelect = 1'b0; wrData = '0;
    for (int b = 0; b < NB; b++) bankRdData[b*DW +: DW] = bankVal(b);

    // reset: no access pending, everything quiet (R1, R2, R11, R12)
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkIdle("reset");
    rst_n = 1'b1;

    // vector table, each as read then write (R12 same decision)
    for (int i = 0; i < NV; i++) begin
      for (int w = 0; w < 2; w++) begin
        vec_t v;
        logic [NB-1:0] expWr;
        logic [DW-1:0] expRd;
        logic expRv;
        v = vec_t'(VECS[i]);
        apply(v, w[0]);
        @(negedge clk);
        expWr = (v.eo == OK_ && w == 1) ? NB'(1) << v.eb : '0;
        expRd = (v.eo == OK_ && w == 0) ? bankVal(int'(v.eb)) : '0;
        expRv = (v.eo == OK_ && w == 0);
        chk(vecReq[i], $sformatf("vec%0d wr%0d outcome", i, w), 32'(outcome), 32'(v.eo));
        chk(vecReq[i], $sformatf("vec%0d wr%0d syndrome", i, w), 32'(syndrome), 32'(v.es));
        chk(vecReq[i], $sformatf("vec%0d wr%0d bank", i, w), 32'(bankSel),
            (v.eo == OK_) ? 32'(v.eb) : 32'd0);
        chk("R11", $sformatf("vec%0d wr%0d wrEn", i, w), 32'(bankWrEn), 32'(expWr));
        chk("R12", $sformatf("vec%0d wr%0d rdData", i, w), rdData, expRd);
        chk("R12", $sformatf("vec%0d wr%0d rdValid", i, w), 32'(rdValid), 32'(expRv));
        if (w == 1 && v.eo == OK_)
          chk("R11", $sformatf("vec%0d write data", i), bankWrData, wrData);
      end
    end

    // directed: level-3 access, then drop accValid with same inputs (R1)
    apply(vec_t'(VECS[21]), 1'b1);
    @(posedge clk);
    accValid = 1'b0;
    @(negedge clk);
    checkIdle("idle after permit");

    // directed: failing access withdrawn must also go quiet (R2)
    apply(vec_t'(VECS[0]), 1'b0);
    @(negedge clk);
    chk("R2", "trap syndrome present", 32'(syndrome), 32'h03);
    @(posedge clk);
    accValid = 1'b0;
    @(negedge clk);
    checkIdle("idle after trap");

    // directed: level 1 ignores user enables and trap-general (R8)
    apply(vec_t'(VECS[19]), 1'b0);
    usrTimEn64 = 1'b0; usrTimEn32 = 1'b0; trapGeneral = 1'b1;
    @(negedge clk);
    chk("R8", "level1 user enables ignored", 32'(outcome), 32'(OK_));
    chk("R8", "level1 read value", rdData, bankVal(0));

    repeat (2) @(posedge clk);
    finish();
  end

endmodule